// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block issues one command at a time to an asynchronous 8-bit NAND flash device. It drives chip enable, the command latch enable (CLE), the address latch enable (ALE), the write strobe and the IO bus, and it samples the device's ready/busy line. The host presents an opcode, a block number, a page number and a byte offset with a one-cycle start strobe. It sees `busy` for the whole sequence and a one-cycle `done` at its end.

The opcode picks the sequence. The sequencer first waits for the device to report ready. It then latches the opcode byte, followed by the column address and the row address, and a confirm opcode where the command needs one. It ends in one of two ways: it returns at once, or it waits a fixed guard interval and then waits for ready again. The guard interval is counted in clock cycles, derived from the clock period and rounded up. The width of each write strobe phase is a parameter. Transferring data after the command is left to other logic.

Top module: `nand_cmd_seq`

## Requirements
- R1: No write strobe falls while ready/busy is low. After a start, the first strobe falls only once ready/busy has been seen high.
- R2: The first byte of every command is the opcode, latched with CLE=1 and ALE=0. Every address byte is latched with ALE=1 and CLE=0. CLE and ALE are never high together, and no byte goes out beyond those the command defines.
- R3: The column address is two bytes, low byte first. With `BUS16=1` the offset is shifted right by one bit before it is sent. It is sent unshifted when the opcode is one of 90h, ECh, EEh or EFh.
- R4: The row address is page + block × `PAGES_PER_BLOCK`, sent low byte first as bits [7:0] and then [15:8]. With `FIVE_CYC=1` a third byte {4'h0, row[19:16]} follows.
- R5: Random data output (05h) sends the column bytes with no row bytes. It then latches E0h with CLE and completes within `WE_CYCLES`+1 cycles of the last rising strobe, whatever ready/busy shows.
- R6: Read page (00h) latches the confirm opcode 30h after the address. It then waits the guard interval and completes only after ready/busy is high. Any opcode not named in R5, R7 or R8 also ends with the guard interval and the ready wait, but sends no confirm byte.
- R7: Opcodes 10h, 15h, 60h, D0h, 80h, 85h and 70h complete within `WE_CYCLES`+1 cycles of the last address byte's rising strobe, with no guard interval and no ready wait.
- R8: Reset (FFh) sends only the opcode byte, waits the guard interval, and completes only after ready/busy is high.
- R9: Ready/busy is not evaluated for completion until at least ceil(`TWB_NS`×1000 / `CLK_PERIOD_PS`) cycles after the last rising strobe.
- R10: Each strobe is low for exactly `WE_CYCLES` cycles and then high for at least `WE_CYCLES` cycles. IO, CLE and ALE stay constant while the strobe is low and across its rising edge.
- R11: `busy` is high from the cycle after an accepted start until `done`. `done` lasts exactly one cycle. A start while `busy` is high is ignored and produces no bytes and no second `done`.
- R12: Out of reset and whenever idle, chip enable and the write strobe are high, CLE and ALE are low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (taken only when idle) |
| opcode | input | 8 | Command opcode |
| block_num | input | BLOCK_W | Erase block number |
| page_num | input | PAGE_W | Page within the block |
| offset | input | 16 | Byte offset within the page |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | 8 | Command and address byte bus |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench builds the block with `BUS16=1` and `FIVE_CYC=1`. This makes both the halved column offset and the unshifted 8-bit-only opcodes visible, as well as the third row byte. It uses `PAGES_PER_BLOCK=64` and `BLOCK_W=12`, so a block number near the top of the range carries nonzero row bits [19:16]. It uses `WE_CYCLES=2` and a 15-cycle guard interval. With these values the strobe width, the no-wait completion window and the guard-interval latency can each be told apart by cycle count. A device model pulls ready/busy low just after the last byte and holds it low longer than the guard interval, so a sequence that skips or shortens the ready wait finishes early and is caught.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam logic [7:0] OP_READ        = 8'h00;
    localparam logic [7:0] OP_READ_CONF   = 8'h30;
    localparam logic [7:0] OP_RDOUT       = 8'h05;
    localparam logic [7:0] OP_RDOUT_CONF  = 8'hE0;
    localparam logic [7:0] OP_PROG        = 8'h10;
    localparam logic [7:0] OP_CPROG       = 8'h15;
    localparam logic [7:0] OP_ERASE_A     = 8'h60;
    localparam logic [7:0] OP_ERASE_B     = 8'hD0;
    localparam logic [7:0] OP_SEQ_IN      = 8'h80;
    localparam logic [7:0] OP_RND_IN      = 8'h85;
    localparam logic [7:0] OP_STATUS      = 8'h70;
    localparam logic [7:0] OP_RESET       = 8'hFF;
    localparam logic [7:0] OP_ID          = 8'h90;
    localparam logic [7:0] OP_PARAM       = 8'hEC;
    localparam logic [7:0] OP_GETF        = 8'hEE;
    localparam logic [7:0] OP_SETF        = 8'hEF;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE_RDY, ST_CMD, ST_COL0, ST_COL1, ST_ROW0, ST_ROW1,
        ST_ROW2, ST_CONF, ST_TWB, ST_POST_RDY, ST_FINISH
    } seq_state_e;

    // How a command ends once its address bytes are out
    typedef enum logic [1:0] {
        TAIL_WAIT, TAIL_NONE, TAIL_CONF_WAIT, TAIL_CONF_NOWAIT
    } tail_e;

    typedef struct packed {
        logic       is_reset;
        logic       skip_row;
        tail_e      tail;
        logic [7:0] conf;
    } cmd_class_t;

    function automatic cmd_class_t classify(input logic [7:0] op);
        cmd_class_t c;
        c.is_reset = 1'b0;
        c.skip_row = 1'b0;
        c.tail     = TAIL_WAIT;
        c.conf     = 8'h00;
        case (op)
            OP_RESET: c.is_reset = 1'b1;
            OP_READ: begin
                c.tail = TAIL_CONF_WAIT;
                c.conf = OP_READ_CONF;
            end
            OP_RDOUT: begin
                c.skip_row = 1'b1;
                c.tail     = TAIL_CONF_NOWAIT;
                c.conf     = OP_RDOUT_CONF;
            end
            OP_PROG, OP_CPROG, OP_ERASE_A, OP_ERASE_B,
            OP_SEQ_IN, OP_RND_IN, OP_STATUS: c.tail = TAIL_NONE;
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic is_8bit_only(input logic [7:0] op);
        return (op == OP_ID) || (op == OP_PARAM) || (op == OP_GETF) || (op == OP_SETF);
    endfunction

endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
    import nand_seq_pkg::*;
#(
    parameter int unsigned BLOCK_W         = 12,
    parameter int unsigned PAGE_W          = 6,
    parameter int unsigned PAGES_PER_BLOCK = 64,
    parameter bit          BUS16           = 1'b0
) (
    input  logic [7:0]         opcode,
    input  logic [BLOCK_W-1:0] block_num,
    input  logic [PAGE_W-1:0]  page_num,
    input  logic [15:0]        offset,
    output logic [7:0]         col_b0,
    output logic [7:0]         col_b1,
    output logic [7:0]         row_b0,
    output logic [7:0]         row_b1,
    output logic [7:0]         row_b2
);
    localparam int unsigned ROW_W = 20;

    logic        halve;
    logic [15:0] col;
    logic [ROW_W-1:0] row;

    always_comb begin
        // word addressing on a 16-bit bus, except for byte-only opcodes
        halve  = BUS16 && !is_8bit_only(opcode);
        col    = halve ? {1'b0, offset[15:1]} : offset;
        row    = ROW_W'(32'(page_num) + 32'(block_num) * PAGES_PER_BLOCK);
        col_b0 = col[7:0];
        col_b1 = col[15:8];
        row_b0 = row[7:0];
        row_b1 = row[15:8];
        row_b2 = {4'h0, row[19:16]};
    end

endmodule

// File: rtl/nand_we_pulse.sv
module nand_we_pulse #(
    parameter int unsigned WE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic we_n,
    output logic active,
    output logic fin
);
    localparam int unsigned CNT_W = $clog2(WE_CYCLES + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } pulse_regs_t;

    pulse_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        fin = 1'b0;
        case (r_q.ph)
            PH_IDLE: if (go) begin
                r_d.ph  = PH_LOW;
                r_d.cnt = CNT_W'(WE_CYCLES - 1);
            end
            PH_LOW: if (r_q.cnt == '0) begin
                r_d.ph  = PH_HIGH;
                r_d.cnt = CNT_W'(WE_CYCLES - 1);
            end else begin
                r_d.cnt = r_q.cnt - CNT_W'(1);
            end
            PH_HIGH: if (r_q.cnt == '0) begin
                r_d.ph = PH_IDLE;
                fin    = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt - CNT_W'(1);
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph  <= PH_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign we_n   = (r_q.ph != PH_LOW);
    assign active = (r_q.ph != PH_IDLE);

    // a new strobe is only requested between strobes
    assert_go_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int unsigned BLOCK_W         = 12,
    parameter int unsigned PAGE_W          = 6,
    parameter int unsigned PAGES_PER_BLOCK = 64,
    parameter bit          BUS16           = 1'b0,
    parameter bit          FIVE_CYC        = 1'b0,
    parameter int unsigned WE_CYCLES       = 2,
    parameter int unsigned CLK_PERIOD_PS   = 10000,
    parameter int unsigned TWB_NS          = 150
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         opcode,
    input  logic [BLOCK_W-1:0] block_num,
    input  logic [PAGE_W-1:0]  page_num,
    input  logic [15:0]        offset,
    output logic               busy,
    output logic               done,
    output logic               nand_ce_n,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_we_n,
    output logic [7:0]         nand_io,
    input  logic               nand_rb_n
);
    localparam int unsigned TWB_CYC = (TWB_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int unsigned TWB_W   = $clog2(TWB_CYC + 1);

    typedef struct packed {
        seq_state_e         state;
        logic [7:0]         op;
        logic [BLOCK_W-1:0] blk;
        logic [PAGE_W-1:0]  pg;
        logic [15:0]        offs;
        logic [TWB_W-1:0]   twb;
    } seq_regs_t;

    seq_regs_t  r_d, r_q;
    cmd_class_t cls;
    seq_state_e after_addr, byte_next;
    logic       pulse_go, pulse_active, pulse_fin;
    logic [7:0] col_b0, col_b1, row_b0, row_b1, row_b2;

    nand_addr_gen #(
        .BLOCK_W(BLOCK_W), .PAGE_W(PAGE_W),
        .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .BUS16(BUS16)
    ) u_addr (
        .opcode(r_q.op), .block_num(r_q.blk), .page_num(r_q.pg), .offset(r_q.offs),
        .col_b0(col_b0), .col_b1(col_b1),
        .row_b0(row_b0), .row_b1(row_b1), .row_b2(row_b2)
    );

    nand_we_pulse #(.WE_CYCLES(WE_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .go(pulse_go),
        .we_n(nand_we_n), .active(pulse_active), .fin(pulse_fin)
    );

    // successor of each byte-latch state
    always_comb begin
        cls = classify(r_q.op);
        case (cls.tail)
            TAIL_NONE:                        after_addr = ST_FINISH;
            TAIL_CONF_WAIT, TAIL_CONF_NOWAIT: after_addr = ST_CONF;
            default:                          after_addr = ST_TWB;
        endcase
        case (r_q.state)
            ST_CMD:  byte_next = cls.is_reset ? ST_TWB : ST_COL0;
            ST_COL0: byte_next = ST_COL1;
            ST_COL1: byte_next = cls.skip_row ? ST_CONF : ST_ROW0;
            ST_ROW0: byte_next = ST_ROW1;
            ST_ROW1: byte_next = FIVE_CYC ? ST_ROW2 : after_addr;
            ST_ROW2: byte_next = after_addr;
            ST_CONF: byte_next = (cls.tail == TAIL_CONF_WAIT) ? ST_TWB : ST_FINISH;
            default: byte_next = ST_IDLE;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        pulse_go = 1'b0;
        case (r_q.state)
            ST_IDLE: if (start) begin
                r_d.state = ST_PRE_RDY;
                r_d.op    = opcode;
                r_d.blk   = block_num;
                r_d.pg    = page_num;
                r_d.offs  = offset;
            end
            ST_PRE_RDY: if (nand_rb_n) r_d.state = ST_CMD;
            ST_CMD, ST_COL0, ST_COL1, ST_ROW0, ST_ROW1, ST_ROW2, ST_CONF: begin
                pulse_go = !pulse_active;
                if (pulse_fin) r_d.state = byte_next;
            end
            ST_TWB: if (r_q.twb == '0) r_d.state = ST_POST_RDY;
                    else r_d.twb = r_q.twb - TWB_W'(1);
            ST_POST_RDY: if (nand_rb_n) r_d.state = ST_FINISH;
            ST_FINISH: r_d.state = ST_IDLE;
            default:   r_d.state = ST_IDLE;
        endcase
        if (r_d.state == ST_TWB && r_q.state != ST_TWB)
            r_d.twb = TWB_W'(TWB_CYC - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.op    <= '0;
            r_q.blk   <= '0;
            r_q.pg    <= '0;
            r_q.offs  <= '0;
            r_q.twb   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // pin decode from the registered state
    always_comb begin
        nand_cle = 1'b0;
        nand_ale = 1'b0;
        nand_io  = 8'h00;
        case (r_q.state)
            ST_CMD:  begin nand_cle = 1'b1; nand_io = r_q.op;   end
            ST_CONF: begin nand_cle = 1'b1; nand_io = cls.conf; end
            ST_COL0: begin nand_ale = 1'b1; nand_io = col_b0;   end
            ST_COL1: begin nand_ale = 1'b1; nand_io = col_b1;   end
            ST_ROW0: begin nand_ale = 1'b1; nand_io = row_b0;   end
            ST_ROW1: begin nand_ale = 1'b1; nand_io = row_b1;   end
            ST_ROW2: begin nand_ale = 1'b1; nand_io = row_b2;   end
            default: ;
        endcase
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign done      = (r_q.state == ST_FINISH);
    assign nand_ce_n = (r_q.state == ST_IDLE);

    // ---------------- checks ----------------
    logic [15:0] low_run_q, since_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q   <= '0;
            since_low_q <= '0;
        end else begin
            low_run_q   <= nand_we_n ? 16'd0 : low_run_q + 16'd1;
            since_low_q <= !nand_we_n ? 16'd0 :
                           (since_low_q == 16'hFFFF ? since_low_q : since_low_q + 16'd1);
        end
    end

    assert_ready_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PRE_RDY && !nand_rb_n) |=> (r_q.state == ST_PRE_RDY));

    assert_latch_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_guard_elapsed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.state == ST_POST_RDY) |-> (32'(since_low_q) >= TWB_CYC));

    assert_low_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (32'(low_run_q) == WE_CYCLES));

    assert_bus_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |=> ($stable(nand_io) && $stable(nand_cle) && $stable(nand_ale)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(r_q.op) && $stable(r_q.offs)));

    assert_idle_pins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_ce_n && nand_we_n && !nand_cle && !nand_ale && !done));

endmodule

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;
    localparam int unsigned BW = 12, PW = 6, PPB = 64, WE = 2;
    localparam int unsigned CLK_PS = 10000, TWB_NS = 150;
    localparam bit B16 = 1'b1, FIVE = 1'b1;
    localparam int TWB_CYC = (TWB_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam logic [7:0] NOWAIT_OPS [7] = '{8'h10, 8'h15, 8'h60, 8'hD0, 8'h80, 8'h85, 8'h70};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rb_n = 1'b1;
    logic [7:0] opcode = '0;
    logic [BW-1:0] blk = '0;
    logic [PW-1:0] pg = '0;
    logic [15:0] offs = '0;
    logic busy, done, ce_n, cle, ale, we_n;
    logic [7:0] io;

    always #5 clk = ~clk;

    nand_cmd_seq #(
        .BLOCK_W(BW), .PAGE_W(PW), .PAGES_PER_BLOCK(PPB), .BUS16(B16), .FIVE_CYC(FIVE),
        .WE_CYCLES(WE), .CLK_PERIOD_PS(CLK_PS), .TWB_NS(TWB_NS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .block_num(blk),
        .page_num(pg), .offset(offs), .busy(busy), .done(done), .nand_ce_n(ce_n),
        .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_io(io), .nand_rb_n(rb_n)
    );

    int checks = 0, fails = 0;
    logic [9:0] exp_q[$];
    string tag_q[$];
    int cyc = 0, low_len = 0, last_rise = 0, first_fall = -1, done_cyc = 0, done_total = 0;
    int busy_s = 0, busy_e = 0, busy_len = 0, pre_until = 0;
    logic we_prev = 1'b1, done_prev = 1'b0, arm_busy = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input logic [9:0] item, input string tag);
        exp_q.push_back(item);
        tag_q.push_back(tag);
    endtask

    // monitor: one item per rising write strobe, plus device ready/busy model
    always @(negedge clk) begin
        logic [9:0] item;
        string tg;
        cyc++;
        if (rst_n) begin
            if (we_prev && !we_n) begin
                chk(rb_n, "R1 strobe fell while device busy", int'(rb_n), 1);
                if (first_fall < 0) first_fall = cyc;
            end
            if (!we_n) low_len++;
            if (!we_prev && we_n) begin
                chk(low_len == WE, "R10 strobe low width", low_len, WE);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected byte on bus", int'({cle, ale, io}), -1);
                end else begin
                    item = exp_q.pop_front();
                    tg   = tag_q.pop_front();
                    chk({cle, ale, io} == item, tg, int'({cle, ale, io}), int'(item));
                    if (exp_q.size() == 0 && arm_busy) begin
                        busy_s = cyc + 2;
                        busy_e = cyc + 2 + busy_len;
                    end
                end
                last_rise = cyc;
                low_len   = 0;
            end
            if (done && done_prev) chk(1'b0, "R11 done wider than one cycle", 2, 1);
            if (done && !done_prev) begin
                done_total++;
                done_cyc = cyc;
            end
        end
        we_prev   = we_n;
        done_prev = done;
        rb_n = !((cyc >= busy_s && cyc < busy_e) || cyc < pre_until);
    end

    task automatic issue_cmd(input logic [7:0] op, input int b, input int p, input int o,
                             input int blen);
        logic [31:0] col, row;
        bit byte_only;
        byte_only = (op == 8'h90) || (op == 8'hEC) || (op == 8'hEE) || (op == 8'hEF);
        col = (B16 && !byte_only) ? (32'(o) >> 1) : 32'(o);
        row = 32'(p) + 32'(b) * PPB;
        push({2'b10, op}, "R2 opcode byte with CLE");
        if (op != 8'hFF) begin
            push({2'b01, col[7:0]}, "R3 column low byte");
            push({2'b01, col[15:8]}, "R3 column high byte");
            if (op != 8'h05) begin
                push({2'b01, row[7:0]}, "R4 row low byte");
                push({2'b01, row[15:8]}, "R4 row middle byte");
                if (FIVE) push({2'b01, 4'h0, row[19:16]}, "R4 third row byte");
            end
            if (op == 8'h00) push({2'b10, 8'h30}, "R6 read confirm byte");
            if (op == 8'h05) push({2'b10, 8'hE0}, "R5 random-out confirm byte");
        end
        arm_busy = 1'b1;
        busy_len = blen;
        busy_s = 0;
        busy_e = 0;
        @(negedge clk);
        start = 1'b1; opcode = op; blk = BW'(b); pg = PW'(p); offs = 16'(o);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_cmd(input bit wait_exp, input string tag);
        int d0, t;
        d0 = done_total;
        t = 0;
        chk(busy, "R11 busy during command", int'(busy), 1);
        while (done_total == d0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(done_total == d0 + 1, {tag, " completion"}, done_total - d0, 1);
        chk(exp_q.size() == 0, "R2 all expected bytes issued", exp_q.size(), 0);
        if (wait_exp) begin
            chk(done_cyc - last_rise >= TWB_CYC, "R9 guard interval before ready",
                done_cyc - last_rise, TWB_CYC);
            if (busy_len > 0)
                chk(done_cyc > busy_e, {tag, " waited for ready"}, done_cyc, busy_e + 1);
        end else begin
            chk(done_cyc - last_rise <= WE + 1, {tag, " ends right after bytes"},
                done_cyc - last_rise, WE + 1);
        end
        arm_busy = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        chk(ce_n && we_n && !cle && !ale && !busy && !done, "R12 pins during reset",
            int'({ce_n, we_n, cle, ale, busy, done}), 'b110000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ce_n && we_n && !cle && !ale && !busy && !done, "R12 pins idle after reset",
            int'({ce_n, we_n, cle, ale, busy, done}), 'b110000);

        // read page with device busy at start: R1, R3 (halved), R4 (third byte), R6
        first_fall = -1;
        pre_until = cyc + 25;
        issue_cmd(8'h00, 1500, 5, 16'h0847, 30);
        finish_cmd(1'b1, "R6 read page");
        chk(first_fall >= pre_until, "R1 first strobe after ready", first_fall, pre_until);

        // reset with no busy period: guard interval alone sets latency (R8, R9)
        issue_cmd(8'hFF, 0, 0, 0, 0);
        finish_cmd(1'b1, "R8 reset");
        // reset with a long busy period
        issue_cmd(8'hFF, 0, 0, 0, 30);
        finish_cmd(1'b1, "R8 reset");

        // random data out: column only, confirm, no wait
        issue_cmd(8'h05, 77, 3, 16'h1234, 30);
        finish_cmd(1'b0, "R5 random data out");

        // commands that return after addressing
        for (int i = 0; i < 7; i++) begin
            issue_cmd(NOWAIT_OPS[i], 200 + i * 300, i * 9, 16'h0102 * (i + 1), 30);
            finish_cmd(1'b0, "R7 no-wait opcode");
        end

        // byte-only opcode: offset not halved, ends with guard and ready wait
        issue_cmd(8'h90, 4095, 63, 16'h00AB, 25);
        finish_cmd(1'b1, "R6 other opcode");

        // start while busy is ignored
        d = done_total;
        issue_cmd(8'h00, 3, 7, 16'h0010, 20);
        repeat (6) @(negedge clk);
        start = 1'b1; opcode = 8'h70; offs = 16'hFFFF;
        @(negedge clk);
        start = 1'b0;
        finish_cmd(1'b1, "R6 read page");
        repeat (60) @(negedge clk);
        chk(done_total == d + 1, "R11 start while busy ignored", done_total - d, 1);
        chk(!busy && ce_n, "R12 idle after ignored start", int'({busy, ce_n}), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule